// File: doc/BRIEF.md
# Integer ALU with Overflow Flag

This block is the integer execute stage of a three-operand load/store core. Each cycle it takes an operation code, two register operands, a 16-bit immediate field and a 5-bit shift-count field. One clock edge later it presents a 32-bit result and an overflow flag on registered outputs. It covers wrapping and trapping add and subtract, signed and unsigned set-on-less-than, four bitwise functions, shifts by a constant or by a register count, and placing an immediate in the upper half of the result.

The immediate is widened differently for each class of operation. Arithmetic and compare forms replicate its top bit, and this includes the forms with unsigned in their name. Bitwise forms pad it with zeros. The overflow flag only reports the condition. Whatever trap follows it belongs to the surrounding core.

Top module: `int_alu_core`

## Requirements
- R1: `result_q` and `ovf_q` are registered: the values for inputs sampled at one rising edge appear after that edge. A synchronous active-high `rst` clears both outputs to 0.
- R2: ADD (code 0), ADDU (1), SUB (2) and SUBU (3) return `opnd_a` plus or minus `opnd_b`, modulo 2^32. ADDI (4) and ADDIU (5) return `opnd_a` plus the extended immediate.
- R3: ADD, SUB and ADDI raise `ovf_q` exactly when the two's-complement result does not fit. For an add, the operands share a sign and the result's sign differs. For a subtract, the operand signs differ and the result's sign differs from `opnd_a`.
- R4: ADDU, SUBU and ADDIU never raise `ovf_q`, and neither does any other operation outside the three trapping forms.
- R5: ADDI, ADDIU, SLTI and SLTIU widen `imm16` by copying its bit 15 into bits 31:16.
- R6: ANDI (14), ORI (15) and XORI (16) widen `imm16` with bits 31:16 forced to 0.
- R7: SLT (6) and SLTI (8) compare as signed values. SLTU (7) and SLTIU (9) compare as unsigned values, and SLTIU does so after sign-extending the immediate. Each returns 1 when `opnd_a` is less than the second operand and 0 otherwise.
- R8: AND (10), OR (11), XOR (12) and NOR (13) act bitwise on `opnd_a` and `opnd_b`. NOR returns the inverse of their OR.
- R9: SLL (17), SRL (18) and SRA (19) shift `opnd_a` by `shamt`. SRA fills the vacated bits with bit 31 of `opnd_a`, and the other two fill with zeros.
- R10: SLLV (20), SRLV (21) and SRAV (22) shift `opnd_a` by `opnd_b[4:0]`. The upper bits of `opnd_b` and the `shamt` field are ignored.
- R11: LUI (23) returns `imm16` in bits 31:16 and zeros in bits 15:0.
- R12: Codes 24 to 31 return a result of 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | First register operand; value to shift |
| opnd_b | input | 32 | Second register operand; count for variable shifts |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift count |
| result_q | output | 32 | Registered result |
| ovf_q | output | 1 | Registered two's-complement overflow flag |

## Verification
The hardest cases to reach are the sign-boundary cases where a single operation code decides whether overflow is reported. Examples are the most positive value plus one, the most negative value minus one, and a subtract of minus one from the most positive value. The stimulus applies the same operand pair under the trapping code and then under its wrapping twin. It also includes immediate forms whose bit 15 is set, because those show whether sign or zero extension was chosen. Variable shifts are driven with junk in the upper count bits and a nonzero `shamt`, so that reading the wrong count shows up at the output.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_SLT   = 5'd6,  OP_SLTU  = 5'd7,
    OP_SLTI  = 5'd8,  OP_SLTIU = 5'd9,  OP_AND   = 5'd10, OP_OR    = 5'd11,
    OP_XOR   = 5'd12, OP_NOR   = 5'd13, OP_ANDI  = 5'd14, OP_ORI   = 5'd15,
    OP_XORI  = 5'd16, OP_SLL   = 5'd17, OP_SRL   = 5'd18, OP_SRA   = 5'd19,
    OP_SLLV  = 5'd20, OP_SRLV  = 5'd21, OP_SRAV  = 5'd22, OP_LUI   = 5'd23
  } alu_op_e;

  localparam int OP_W = 5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ARITH, SEL_LT_S, SEL_LT_U, SEL_BITS, SEL_SHIFT, SEL_UPPER
  } res_sel_e;

  typedef enum logic [1:0] {
    BF_AND, BF_OR, BF_XOR, BF_NOR
  } bit_fn_e;

  function automatic logic is_trap_op(input logic [OP_W-1:0] code);
    return (code == OP_ADD) || (code == OP_SUB) || (code == OP_ADDI);
  endfunction

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              zero_ext,
  output logic [DATA_W-1:0] ext
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic pad_bit;
  assign pad_bit = imm[IMM_W-1] & ~zero_ext;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi < IMM_W) begin : g_low
        assign ext[gi] = imm[gi];
      end else begin : g_pad
        assign ext[gi] = pad_bit;
      end
    end
  endgenerate

  initial begin
    if (PAD_W < 1) $error("alu_imm_ext: DATA_W must exceed IMM_W");
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  assign sum   = wide[MSB:0];

  // operands of like sign (after inversion for subtract) producing the other sign
  assign ovf         = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  assign lt_signed   = sum[MSB] ^ ovf;
  assign lt_unsigned = ~wide[DATA_W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  input  alu_pkg::bit_fn_e      fn,
  output logic [DATA_W-1:0]     y
);
  import alu_pkg::*;

  always_comb begin
    unique case (fn)
      BF_AND:  y = a & b;
      BF_OR:   y = a | b;
      BF_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [SH_W-1:0]   count,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] y
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] pre;
  logic [DATA_W-1:0] post;
  logic [DATA_W-1:0] stg;
  logic              fill;

  assign fill = arith & ~left & value[MSB];

  // left shifts reuse the right-shift network on bit-reversed data
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign pre[gi] = left ? value[MSB-gi] : value[gi];
      assign y[gi]   = left ? post[MSB-gi]  : post[gi];
    end
  endgenerate

  always_comb begin
    stg = pre;
    for (int s = 0; s < SH_W; s++) begin
      if (count[s]) begin
        stg = (stg >> (1 << s)) |
              (fill ? ~({DATA_W{1'b1}} >> (1 << s)) : {DATA_W{1'b0}});
      end
    end
    post = stg;
  end
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int OPW   = alu_pkg::OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPW-1:0]    op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result_q,
  output logic              ovf_q
);
  import alu_pkg::*;

  localparam int MSB   = DATA_W - 1;
  localparam int LOW_W = DATA_W - IMM_W;

  // decode controls
  res_sel_e sel;
  bit_fn_e  bfn;
  logic     use_imm, zero_ext, do_sub, trap;
  logic     sh_left, sh_arith, sh_var;

  always_comb begin
    sel      = SEL_NONE;
    bfn      = BF_AND;
    use_imm  = 1'b0;
    zero_ext = 1'b0;
    do_sub   = 1'b0;
    trap     = 1'b0;
    sh_left  = 1'b0;
    sh_arith = 1'b0;
    sh_var   = 1'b0;
    case (op_sel)
      OP_ADD:   begin sel = SEL_ARITH; trap = 1'b1; end
      OP_ADDU:  begin sel = SEL_ARITH; end
      OP_SUB:   begin sel = SEL_ARITH; do_sub = 1'b1; trap = 1'b1; end
      OP_SUBU:  begin sel = SEL_ARITH; do_sub = 1'b1; end
      OP_ADDI:  begin sel = SEL_ARITH; use_imm = 1'b1; trap = 1'b1; end
      OP_ADDIU: begin sel = SEL_ARITH; use_imm = 1'b1; end
      OP_SLT:   begin sel = SEL_LT_S; do_sub = 1'b1; end
      OP_SLTU:  begin sel = SEL_LT_U; do_sub = 1'b1; end
      OP_SLTI:  begin sel = SEL_LT_S; do_sub = 1'b1; use_imm = 1'b1; end
      OP_SLTIU: begin sel = SEL_LT_U; do_sub = 1'b1; use_imm = 1'b1; end
      OP_AND:   begin sel = SEL_BITS; bfn = BF_AND; end
      OP_OR:    begin sel = SEL_BITS; bfn = BF_OR;  end
      OP_XOR:   begin sel = SEL_BITS; bfn = BF_XOR; end
      OP_NOR:   begin sel = SEL_BITS; bfn = BF_NOR; end
      OP_ANDI:  begin sel = SEL_BITS; bfn = BF_AND; use_imm = 1'b1; zero_ext = 1'b1; end
      OP_ORI:   begin sel = SEL_BITS; bfn = BF_OR;  use_imm = 1'b1; zero_ext = 1'b1; end
      OP_XORI:  begin sel = SEL_BITS; bfn = BF_XOR; use_imm = 1'b1; zero_ext = 1'b1; end
      OP_SLL:   begin sel = SEL_SHIFT; sh_left = 1'b1; end
      OP_SRL:   begin sel = SEL_SHIFT; end
      OP_SRA:   begin sel = SEL_SHIFT; sh_arith = 1'b1; end
      OP_SLLV:  begin sel = SEL_SHIFT; sh_left = 1'b1; sh_var = 1'b1; end
      OP_SRLV:  begin sel = SEL_SHIFT; sh_var = 1'b1; end
      OP_SRAV:  begin sel = SEL_SHIFT; sh_arith = 1'b1; sh_var = 1'b1; end
      OP_LUI:   begin sel = SEL_UPPER; end
      default:  begin sel = SEL_NONE; end
    endcase
  end

  // operand preparation
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_2;
  logic [SH_W-1:0]   sh_cnt;

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm      (imm16),
    .zero_ext (zero_ext),
    .ext      (imm_ext)
  );

  assign opnd_2 = use_imm ? imm_ext : opnd_b;
  assign sh_cnt = sh_var ? opnd_b[SH_W-1:0] : shamt;

  // functional units
  logic [DATA_W-1:0] arith_y, bits_y, shift_y;
  logic              arith_ovf, lt_s, lt_u;

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .a           (opnd_a),
    .b           (opnd_2),
    .sub         (do_sub),
    .sum         (arith_y),
    .ovf         (arith_ovf),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_bits (
    .a  (opnd_a),
    .b  (opnd_2),
    .fn (bfn),
    .y  (bits_y)
  );

  alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .value (opnd_a),
    .count (sh_cnt),
    .left  (sh_left),
    .arith (sh_arith),
    .y     (shift_y)
  );

  // result select
  logic [DATA_W-1:0] res_d;
  logic              ovf_d;

  always_comb begin
    unique case (sel)
      SEL_ARITH: res_d = arith_y;
      SEL_LT_S:  res_d = {{(DATA_W-1){1'b0}}, lt_s};
      SEL_LT_U:  res_d = {{(DATA_W-1){1'b0}}, lt_u};
      SEL_BITS:  res_d = bits_y;
      SEL_SHIFT: res_d = shift_y;
      SEL_UPPER: res_d = {imm16, {LOW_W{1'b0}}};
      default:   res_d = '0;
    endcase
    ovf_d = trap & arith_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      result_q <= res_d;
      ovf_q    <= ovf_d;
    end
  end

  // R3 R4
  trap_only_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> is_trap_op($past(op_sel)));

  // R7
  lt_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI || op_sel == OP_SLTIU)
      |=> (result_q[MSB:1] == '0));

  // R11
  upper_place_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_LUI) |=> (result_q[LOW_W-1:0] == '0) &&
                           (result_q[MSB -: IMM_W] == $past(imm16)));

  // R6
  andi_zero_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ANDI) |=> (result_q[MSB:IMM_W] == '0));

  // R9
  sra_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SRA && opnd_a[MSB]) |=> result_q[MSB]);

  // R12
  undef_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel > OP_LUI) |=> (result_q == '0) && !ovf_q);

endmodule

// File: tb/tb_int_alu_core.sv
module tb_int_alu_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm16;
  logic [4:0]  shamt;
  logic [31:0] result_q;
  logic        ovf_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_core dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm16(imm16), .shamt(shamt), .result_q(result_q), .ovf_q(ovf_q)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic [31:0] res;
    logic        ovf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  32'h00000005, 32'h00000007, 16'h0000, 5'd0,  32'h0000000C, 1'b0, 4'd2},  // R2 ADD
    '{5'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h80000000, 1'b1, 4'd3},  // R3 ADD +ovf
    '{5'd0,  32'h80000000, 32'h80000000, 16'h0000, 5'd0,  32'h00000000, 1'b1, 4'd3},  // R3 ADD -ovf
    '{5'd1,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h80000000, 1'b0, 4'd4},  // R4 ADDU
    '{5'd2,  32'h80000000, 32'h00000001, 16'h0000, 5'd0,  32'h7FFFFFFF, 1'b1, 4'd3},  // R3 SUB
    '{5'd2,  32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0000, 5'd0,  32'h80000000, 1'b1, 4'd3},  // R3 SUB
    '{5'd2,  32'h0000000A, 32'h00000003, 16'h0000, 5'd0,  32'h00000007, 1'b0, 4'd2},  // R2 SUB
    '{5'd3,  32'h00000000, 32'h00000001, 16'h0000, 5'd0,  32'hFFFFFFFF, 1'b0, 4'd4},  // R4 SUBU
    '{5'd3,  32'h80000000, 32'h00000001, 16'h0000, 5'd0,  32'h7FFFFFFF, 1'b0, 4'd4},  // R4 SUBU
    '{5'd4,  32'h7FFFFFFF, 32'h00000000, 16'h0001, 5'd0,  32'h80000000, 1'b1, 4'd3},  // R3 ADDI
    '{5'd4,  32'h00000001, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000000, 1'b0, 4'd5},  // R5 ADDI -1
    '{5'd4,  32'h00000000, 32'h00000000, 16'h8000, 5'd0,  32'hFFFF8000, 1'b0, 4'd5},  // R5 ADDI
    '{5'd5,  32'h00000010, 32'h00000000, 16'hFFFF, 5'd0,  32'h0000000F, 1'b0, 4'd5},  // R5 ADDIU
    '{5'd5,  32'h7FFFFFFF, 32'h00000000, 16'h0001, 5'd0,  32'h80000000, 1'b0, 4'd4},  // R4 ADDIU
    '{5'd6,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001, 1'b0, 4'd7},  // R7 SLT
    '{5'd6,  32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000000, 1'b0, 4'd7},  // R7 SLT eq
    '{5'd7,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000, 1'b0, 4'd7},  // R7 SLTU
    '{5'd8,  32'hFFFFFFFE, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001, 1'b0, 4'd7},  // R7 SLTI
    '{5'd9,  32'h00001000, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001, 1'b0, 4'd7},  // R7 SLTIU
    '{5'd9,  32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000000, 1'b0, 4'd7},  // R7 SLTIU eq
    '{5'd10, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 5'd0,  32'hF000F000, 1'b0, 4'd8},  // R8 AND
    '{5'd11, 32'hF0F0F0F0, 32'h0F0F0000, 16'h0000, 5'd0,  32'hFFFFF0F0, 1'b0, 4'd8},  // R8 OR
    '{5'd12, 32'hFFFF0000, 32'hFF00FF00, 16'h0000, 5'd0,  32'h00FFFF00, 1'b0, 4'd8},  // R8 XOR
    '{5'd13, 32'h0F0F0F0F, 32'h00FF0000, 16'h0000, 5'd0,  32'hF000F0F0, 1'b0, 4'd8},  // R8 NOR
    '{5'd14, 32'hFFFFFFFF, 32'h00000000, 16'h8001, 5'd0,  32'h00008001, 1'b0, 4'd6},  // R6 ANDI
    '{5'd15, 32'h12340000, 32'h00000000, 16'h8000, 5'd0,  32'h12348000, 1'b0, 4'd6},  // R6 ORI
    '{5'd16, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 5'd0,  32'hFFFF0000, 1'b0, 4'd6},  // R6 XORI
    '{5'd17, 32'h00000001, 32'h00000000, 16'h0000, 5'd31, 32'h80000000, 1'b0, 4'd9},  // R9 SLL
    '{5'd17, 32'hDEADBEEF, 32'h00000005, 16'h0000, 5'd0,  32'hDEADBEEF, 1'b0, 4'd9},  // R9 SLL 0
    '{5'd18, 32'h80000000, 32'h00000000, 16'h0000, 5'd4,  32'h08000000, 1'b0, 4'd9},  // R9 SRL
    '{5'd19, 32'h80000000, 32'h00000000, 16'h0000, 5'd4,  32'hF8000000, 1'b0, 4'd9},  // R9 SRA neg
    '{5'd19, 32'h40000000, 32'h00000000, 16'h0000, 5'd4,  32'h04000000, 1'b0, 4'd9},  // R9 SRA pos
    '{5'd20, 32'h00000003, 32'h00000024, 16'h0000, 5'd1,  32'h00000030, 1'b0, 4'd10}, // R10 SLLV
    '{5'd21, 32'hF0000000, 32'hFFFFFFE8, 16'h0000, 5'd3,  32'h00F00000, 1'b0, 4'd10}, // R10 SRLV
    '{5'd22, 32'hF0000000, 32'h00000021, 16'h0000, 5'd7,  32'hF8000000, 1'b0, 4'd10}, // R10 SRAV
    '{5'd23, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 5'd9,  32'hABCD0000, 1'b0, 4'd11}  // R11 LUI
  };

  task automatic check(input string tag, input logic [31:0] exp_res, input logic exp_ovf);
    checks++;
    if (result_q !== exp_res || ovf_q !== exp_ovf) begin
      fails++;
      $display("FAIL %s: actual result=%h ovf=%b expected result=%h ovf=%b",
               tag, result_q, ovf_q, exp_res, exp_ovf);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic [4:0] sh);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm16 = imm; shamt = sh;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    op_sel = 5'd0; opnd_a = '0; opnd_b = '0; imm16 = '0; shamt = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 32'h0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
      check($sformatf("R%0d vector %0d op %0d", VECS[i].req, i, VECS[i].op),
            VECS[i].res, VECS[i].ovf);
    end

    // R12: every undefined code yields zero and no flag
    for (int c = 24; c < 32; c++) begin
      drive(5'(c), 32'h7FFFFFFF, 32'h00000001, 16'hFFFF, 5'd3);
      check($sformatf("R12 undefined op %0d", c), 32'h0, 1'b0);
    end

    // R1: result appears only after the edge; previous value visible before it
    drive(5'd0, 32'h00000001, 32'h00000002, 16'h0, 5'd0);
    @(negedge clk);
    op_sel = 5'd0; opnd_a = 32'h00000010; opnd_b = 32'h00000020;
    #1 check("R1 held before edge", 32'h00000003, 1'b0);
    @(negedge clk);
    check("R1 updated after edge", 32'h00000030, 1'b0);

    // R1: synchronous reset clears an overflowing result
    @(negedge clk);
    op_sel = 5'd0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h00000001; rst = 1'b1;
    @(negedge clk);
    check("R1 reset over overflow", 32'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset release", 32'h80000000, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual not finished expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule